// File: doc/BRIEF.md
# Rule-Table Receive Frame Filer

The filer classifies incoming frames against an ordered table of rules. Each frame is presented as a set of 32-bit properties that an upstream parser has already extracted, together with a one-cycle start strobe. The filer then walks the table one rule per clock. The first rule chain that succeeds either rejects the frame or files it to one of up to 64 receive queues. Software loads rules beforehand through a single-cycle write port. Each rule is a 16-bit control word plus a 32-bit value.

A rule compares one selected property against its value using one of four compare modes. Property ID 0 is special: it loads a mask that is ANDed onto every later property of the same frame, and it compares the value against itself. This makes guaranteed-pass and guaranteed-fail filler rules easy to write. Rules marked as chained are ANDed with the rules after them. When a chain fails, the rest of that chain is skipped. A two-bit error code reports one of four outcomes alongside a one-cycle done strobe: clean, disabled queue, partial search, and no match. A separate pulse flags frames that hit a rule tagged for a special-frame interrupt.

The controller has three states. ST_IDLE waits for a start. ST_SEARCH evaluates the table. ST_BYPASS emits the fixed queue-0 result when filing is switched off. The transitions are:
- IDLE or BYPASS to SEARCH on a start with filing enabled.
- IDLE or BYPASS to BYPASS on a start with filing disabled.
- SEARCH to IDLE when a chain succeeds or the last entry is evaluated.
- SEARCH back to SEARCH or to BYPASS when a new start aborts a search.
- BYPASS to IDLE when no start is present.

Top module: `rule_filer`

## Requirements
- R1: Rules are written with `wr_en_i` at `wr_idx_i`. The control word carries the queue in bits 15:10, the interrupt flag in bit 9, reject in bit 8, chain (AND) in bit 7, the compare mode in bits 6:5 and the property ID in bits 4:0. The 32-bit value is written through `wr_val_i`.
- R2: Compare modes are 00 equal, 01 greater-or-equal, 10 not-equal and 11 less-than. Each mode compares the masked property, taken as an unsigned number, against the rule value. Property ID p (1 to 7) selects bits [(p-1)*32 +: 32] of `props_i`, as captured at start.
- R3: A rule with property ID 0 loads the mask with its value and compares the value against itself. The mask returns to all ones at every frame start.
- R4: Rules are evaluated in index order, one per clock. If the first successful rule is at index k, `done_o` rises k+1 rising edges after the edge that samples `start_i`.
- R5: A failing rule with the chain bit set causes every following rule, up to and including the next rule with the chain bit clear, to be skipped. A chain succeeds only when all of its rules match.
- R6: A successful rule with reject set gives `reject_o`=1, `queue_o`=0 and `err_o`=00.
- R7: A successful filing rule reports its queue on `queue_o`. `err_o` is 01 if that queue's bit in `q_en_i` is low, and 00 otherwise.
- R8: If no rule succeeds across all entries, the result is `err_o`=11, `queue_o`=0 and `reject_o`=0, delivered N_RULES edges after the start edge.
- R9: A start that arrives while a search is still unfinished ends that frame with `err_o`=10 and `queue_o`=0 on the same edge, and the new frame's search begins.
- R10: With `filer_en_i` low, a frame is filed to queue 0 one edge after the start edge. `err_o` is 01 if `q_en_i[0]` is low, and 00 otherwise.
- R11: `gpi_o` pulses with `done_o` only when the deciding rule has its interrupt flag set and reject clear. The flag on a chained rule has no effect.
- R12: The result outputs are valid only in the single cycle `done_o` is high. At all other times they read zero.
- R13: After reset, `done_o` is low, all result outputs are zero and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Rule write strobe |
| wr_idx_i | input | 8 | Rule index to write |
| wr_ctrl_i | input | 16 | Rule control word |
| wr_val_i | input | 32 | Rule compare/mask value |
| filer_en_i | input | 1 | Rule search enable; low files every frame to queue 0 |
| q_en_i | input | 64 | Per-queue enable |
| start_i | input | 1 | Frame start strobe, properties valid |
| props_i | input | 224 | Seven 32-bit frame properties, ID 1 in the low bits |
| done_o | output | 1 | Result valid strobe |
| reject_o | output | 1 | Frame discarded |
| queue_o | output | 6 | Destination queue |
| err_o | output | 2 | Outcome code |
| gpi_o | output | 1 | Special-frame interrupt pulse |

## Verification
One property value is run against equal, not-equal, less-than and greater-or-equal rules placed in a known order. The index of the winning rule, read from both the queue and the latency, shows which compare mode matched and that no earlier rule was taken. Two consecutive frames use the same compare rule, first after a mask-loading rule and then without one. This separates a mask that carries over between frames from one that restarts at all ones. Chain patterns are arranged so that the skipped terminating rule would itself match, which tells a true skip apart from plain evaluation. Aborted, exhausted, bypassed and disabled-queue frames each produce a distinct error code and queue that the bench expects.

// File: rtl/rule_filer_pkg.sv
package rule_filer_pkg;

    localparam int CTRL_W = 16;
    localparam int QSEL_W = 6;
    localparam int PID_W  = 5;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_GE = 2'b01,
        CMP_NE = 2'b10,
        CMP_LT = 2'b11
    } cmp_e;

    // Control word, MSB first: queue[15:10] gpi[9] rej[8] chain[7] cmp[6:5] pid[4:0]
    typedef struct packed {
        logic [QSEL_W-1:0] queue;
        logic              gpi;
        logic              rej;
        logic              chain;
        cmp_e              cmp;
        logic [PID_W-1:0]  pid;
    } rule_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SEARCH = 2'b01,
        ST_BYPASS = 2'b10
    } state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_QDIS    = 2'b01,
        ERR_PARTIAL = 2'b10,
        ERR_NOMATCH = 2'b11
    } err_e;

endpackage

// File: rtl/rule_filer_table.sv
module rule_filer_table
    import rule_filer_pkg::*;
#(
    parameter int N_RULES = 256,
    parameter int VAL_W   = 32,
    localparam int IDX_W  = $clog2(N_RULES)
) (
    input  logic              clk_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [CTRL_W-1:0] wr_ctrl_i,
    input  logic [VAL_W-1:0]  wr_val_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output rule_ctrl_t        rd_ctrl_o,
    output logic [VAL_W-1:0]  rd_val_o
);

    rule_ctrl_t       ctrl_mem [N_RULES];
    logic [VAL_W-1:0] val_mem  [N_RULES];

    // R1: single-cycle rule write
    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            ctrl_mem[wr_idx_i] <= rule_ctrl_t'(wr_ctrl_i);
            val_mem[wr_idx_i]  <= wr_val_i;
        end
    end

    assign rd_ctrl_o = ctrl_mem[rd_idx_i];
    assign rd_val_o  = val_mem[rd_idx_i];

endmodule

// File: rtl/rule_filer_eval.sv
module rule_filer_eval
    import rule_filer_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic             mask_rule_i,
    input  cmp_e             cmp_i,
    input  logic [VAL_W-1:0] val_i,
    input  logic [VAL_W-1:0] prop_i,
    input  logic [VAL_W-1:0] mask_i,
    output logic             hit_o
);

    logic [VAL_W-1:0] operand;

    // R3: a mask rule compares its own value
    assign operand = mask_rule_i ? val_i : (prop_i & mask_i);

    // R2: four unsigned compare modes
    always_comb begin
        unique case (cmp_i)
            CMP_EQ:  hit_o = (operand == val_i);
            CMP_GE:  hit_o = (operand >= val_i);
            CMP_NE:  hit_o = (operand != val_i);
            CMP_LT:  hit_o = (operand <  val_i);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rule_filer.sv
module rule_filer
    import rule_filer_pkg::*;
#(
    parameter int N_RULES  = 256,
    parameter int N_QUEUES = 64,
    parameter int N_PROPS  = 8,
    parameter int VAL_W    = 32,
    localparam int IDX_W   = $clog2(N_RULES),
    localparam int PROPS_W = (N_PROPS - 1) * VAL_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic [CTRL_W-1:0]   wr_ctrl_i,
    input  logic [VAL_W-1:0]    wr_val_i,
    input  logic                filer_en_i,
    input  logic [N_QUEUES-1:0] q_en_i,
    input  logic                start_i,
    input  logic [PROPS_W-1:0]  props_i,
    output logic                done_o,
    output logic                reject_o,
    output logic [QSEL_W-1:0]   queue_o,
    output logic [1:0]          err_o,
    output logic                gpi_o
);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [VAL_W-1:0] mask_q;
    logic             chain_fail_q;
    logic [VAL_W-1:0] props_q [1:N_PROPS-1];

    rule_ctrl_t       cur_ctrl;
    logic [VAL_W-1:0] cur_val;
    logic [VAL_W-1:0] sel_prop;
    logic             hit;
    logic             take;
    logic             last;
    logic [63:0]      qen_ext;

    logic             done_q, reject_q, gpi_q;
    logic [QSEL_W-1:0] queue_q;
    logic [1:0]       err_q;

    rule_filer_table #(.N_RULES(N_RULES), .VAL_W(VAL_W)) u_table (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_ctrl_i (wr_ctrl_i),
        .wr_val_i  (wr_val_i),
        .rd_idx_i  (idx_q),
        .rd_ctrl_o (cur_ctrl),
        .rd_val_o  (cur_val)
    );

    always_comb begin
        sel_prop = '0;
        for (int p = 1; p < N_PROPS; p++) begin
            if (cur_ctrl.pid == PID_W'(p)) sel_prop = props_q[p];
        end
    end

    rule_filer_eval #(.VAL_W(VAL_W)) u_eval (
        .mask_rule_i (cur_ctrl.pid == '0),
        .cmp_i       (cur_ctrl.cmp),
        .val_i       (cur_val),
        .prop_i      (sel_prop),
        .mask_i      (mask_q),
        .hit_o       (hit)
    );

    // R5: a chain decides only at its terminating rule, and only if nothing failed
    assign take    = !chain_fail_q && hit && !cur_ctrl.chain;
    assign last    = (idx_q == IDX_W'(N_RULES - 1));
    assign qen_ext = 64'(q_en_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BYPASS: begin
                if (start_i) state_d = filer_en_i ? ST_SEARCH : ST_BYPASS;
                else         state_d = ST_IDLE;
            end
            ST_SEARCH: begin
                if (start_i)           state_d = filer_en_i ? ST_SEARCH : ST_BYPASS;
                else if (take || last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and search datapath
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q      <= ST_IDLE;
            idx_q        <= '0;
            mask_q       <= '1;
            chain_fail_q <= 1'b0;
            for (int p = 1; p < N_PROPS; p++) props_q[p] <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                idx_q        <= '0;
                mask_q       <= '1;   // R3
                chain_fail_q <= 1'b0;
                for (int p = 1; p < N_PROPS; p++)
                    props_q[p] <= props_i[(p-1)*VAL_W +: VAL_W];
            end else if (state_q == ST_SEARCH) begin
                idx_q <= idx_q + IDX_W'(1);   // R4
                if (!chain_fail_q && cur_ctrl.pid == '0) mask_q <= cur_val;
                chain_fail_q <= cur_ctrl.chain ? (chain_fail_q | !hit) : 1'b0;
            end
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            queue_q  <= '0;
            err_q    <= ERR_NONE;
            gpi_q    <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            queue_q  <= '0;
            err_q    <= ERR_NONE;
            gpi_q    <= 1'b0;
            unique case (state_q)
                ST_SEARCH: begin
                    if (take) begin
                        done_q   <= 1'b1;
                        reject_q <= cur_ctrl.rej;
                        queue_q  <= cur_ctrl.rej ? '0 : cur_ctrl.queue;
                        err_q    <= (!cur_ctrl.rej && !qen_ext[cur_ctrl.queue]) ? ERR_QDIS : ERR_NONE;
                        gpi_q    <= cur_ctrl.gpi && !cur_ctrl.rej;
                    end else if (last) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_NOMATCH;
                    end else if (start_i) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_PARTIAL;
                    end
                end
                ST_BYPASS: begin
                    done_q <= 1'b1;
                    err_q  <= qen_ext[0] ? ERR_NONE : ERR_QDIS;
                end
                default: ;
            endcase
        end
    end

    assign done_o   = done_q;
    assign reject_o = reject_q;
    assign queue_o  = queue_q;
    assign err_o    = err_q;
    assign gpi_o    = gpi_q;

    // R12
    idle_outputs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> (err_o == 2'b00 && !reject_o && !gpi_o && queue_o == '0));

    // R11
    gpi_needs_file_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gpi_o |-> (done_o && !reject_o));

    // R8
    nomatch_queue_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o == 2'b11) |-> (!reject_o && queue_o == '0));

    // R9
    partial_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o == 2'b10) |-> ($past(start_i) && $past(state_q) == ST_SEARCH));

    // R6
    reject_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && reject_o) |-> (err_o == 2'b00 && queue_o == '0));

    // R10
    bypass_queue_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(state_q) == ST_BYPASS) |-> (queue_o == '0 && !reject_o));

endmodule

// File: tb/rule_filer_test.sv
module rule_filer_test;

    localparam int N_RULES  = 256;
    localparam int N_QUEUES = 64;
    localparam int N_PROPS  = 8;
    localparam int VAL_W    = 32;
    localparam int PROPS_W  = (N_PROPS - 1) * VAL_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [7:0]          wr_idx = '0;
    logic [15:0]         wr_ctrl = '0;
    logic [31:0]         wr_val = '0;
    logic                filer_en = 1'b1;
    logic [N_QUEUES-1:0] q_en = '1;
    logic                start = 1'b0;
    logic [PROPS_W-1:0]  props = '0;
    logic                done, reject, gpi;
    logic [5:0]          queue;
    logic [1:0]          err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rule_filer uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_ctrl_i(wr_ctrl), .wr_val_i(wr_val), .filer_en_i(filer_en),
        .q_en_i(q_en), .start_i(start), .props_i(props), .done_o(done),
        .reject_o(reject), .queue_o(queue), .err_o(err), .gpi_o(gpi)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put_rule(input int idx, input int q, input bit g, input bit rj,
                            input bit ch, input int cmp, input int pid, input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = 8'(idx);
        wr_ctrl = {q[5:0], g, rj, ch, cmp[1:0], pid[4:0]};
        wr_val  = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic fail_rule(input int idx);
        put_rule(idx, 0, 0, 0, 0, 3, 0, 32'h0);
    endtask

    task automatic set_prop(input int p, input logic [31:0] v);
        props[(p-1)*VAL_W +: VAL_W] = v;
    endtask

    task automatic run_frame(output int lat);
        @(negedge clk);
        start = 1'b1;
        lat = 0;
        while (lat < 400) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done) break;
        end
    endtask

    task automatic expect_result(input string req, input int lat, input int exp_lat,
                                 input bit exp_rej, input int exp_q, input int exp_err, input bit exp_gpi);
        chk(req, "latency", lat, exp_lat);
        chk(req, "done", int'(done), 1);
        chk(req, "reject", int'(reject), int'(exp_rej));
        chk(req, "queue", int'(queue), exp_q);
        chk(req, "err", int'(err), exp_err);
        chk(req, "gpi", int'(gpi), int'(exp_gpi));
    endtask

    task automatic test_reset;
        // R13: quiet outputs after reset
        chk("R13", "done", int'(done), 0);
        chk("R13", "err", int'(err), 0);
        chk("R13", "queue", int'(queue), 0);
        chk("R13", "reject", int'(reject), 0);
    endtask

    task automatic test_compare;
        int lat;
        // R2 R4 R1: eq@0 q1, ne@1 q2, lt@2 q3, ge@3 q7
        put_rule(0, 1, 0, 0, 0, 0, 1, 32'd50);
        put_rule(1, 2, 0, 0, 0, 2, 1, 32'd100);
        put_rule(2, 3, 0, 0, 0, 3, 1, 32'd100);
        put_rule(3, 7, 0, 0, 0, 1, 1, 32'd100);
        set_prop(1, 32'd100);
        run_frame(lat);
        expect_result("R2", lat, 5, 0, 7, 0, 0);
        set_prop(1, 32'd50);
        run_frame(lat);
        expect_result("R4", lat, 2, 0, 1, 0, 0);
        set_prop(1, 32'd99);
        run_frame(lat);
        expect_result("R2", lat, 3, 0, 2, 0, 0);
        for (int i = 0; i < 4; i++) fail_rule(i);
    endtask

    task automatic test_mask;
        int lat;
        // R3: mask loaded by pid 0, restored to all ones per frame
        put_rule(0, 0, 0, 0, 1, 0, 0, 32'h0000_00FF);
        put_rule(1, 9, 0, 0, 0, 0, 1, 32'h0000_0034);
        put_rule(2, 10, 0, 0, 0, 0, 1, 32'h0000_1234);
        set_prop(1, 32'h0000_1234);
        set_prop(2, 32'h0);
        run_frame(lat);
        expect_result("R3", lat, 3, 0, 9, 0, 0);
        put_rule(0, 0, 0, 0, 0, 0, 2, 32'h0000_DEAD);
        run_frame(lat);
        expect_result("R3", lat, 4, 0, 10, 0, 0);
        for (int i = 0; i < 3; i++) fail_rule(i);
    endtask

    task automatic test_chain;
        int lat;
        // R5: chain of three, default file behind it
        put_rule(0, 0, 0, 0, 1, 0, 1, 32'd7);
        put_rule(1, 0, 0, 0, 1, 3, 2, 32'd5);
        put_rule(2, 3, 0, 0, 0, 3, 2, 32'd5);
        put_rule(3, 4, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        set_prop(1, 32'd8); set_prop(2, 32'd1);
        run_frame(lat);
        expect_result("R5", lat, 5, 0, 4, 0, 0);
        set_prop(1, 32'd7);
        run_frame(lat);
        expect_result("R5", lat, 4, 0, 3, 0, 0);
        set_prop(2, 32'd9);
        run_frame(lat);
        expect_result("R5", lat, 5, 0, 4, 0, 0);
        for (int i = 0; i < 4; i++) fail_rule(i);
    endtask

    task automatic test_reject_gpi;
        int lat;
        // R6 R11: default reject with interrupt flag
        put_rule(0, 5, 1, 1, 0, 1, 0, 32'hFFFF_FFFF);
        run_frame(lat);
        expect_result("R6", lat, 2, 1, 0, 0, 0);
        // R11: flag on the chained empty rule has no effect
        put_rule(0, 0, 1, 0, 1, 1, 0, 32'h0);
        put_rule(1, 6, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        run_frame(lat);
        expect_result("R11", lat, 3, 0, 6, 0, 0);
        put_rule(1, 6, 1, 0, 0, 1, 0, 32'hFFFF_FFFF);
        run_frame(lat);
        expect_result("R11", lat, 3, 0, 6, 0, 1);
        // R12: next cycle quiet
        @(negedge clk);
        chk("R12", "done", int'(done), 0);
        chk("R12", "gpi", int'(gpi), 0);
        chk("R12", "queue", int'(queue), 0);
        fail_rule(0); fail_rule(1);
    endtask

    task automatic test_qdis;
        int lat;
        // R7: queue 4 disabled, queue 5 enabled
        q_en = '1; q_en[4] = 1'b0;
        put_rule(0, 4, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        run_frame(lat);
        expect_result("R7", lat, 2, 0, 4, 1, 0);
        put_rule(0, 5, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        run_frame(lat);
        expect_result("R7", lat, 2, 0, 5, 0, 0);
        q_en = '1;
        fail_rule(0);
    endtask

    task automatic test_nomatch;
        int lat;
        // R8: whole table fails
        run_frame(lat);
        expect_result("R8", lat, N_RULES + 1, 0, 0, 3, 0);
    endtask

    task automatic test_partial;
        int lat;
        // R9: abort after 10 cycles of search
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R9", "done before abort", int'(done), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "abort done", int'(done), 1);
        chk("R9", "abort err", int'(err), 2);
        chk("R9", "abort queue", int'(queue), 0);
        lat = 1;
        while (lat < 400) begin
            @(negedge clk);
            lat++;
            if (done) break;
        end
        expect_result("R9", lat, N_RULES + 1, 0, 0, 3, 0);
    endtask

    task automatic test_bypass;
        int lat;
        // R10: filing off, queue 0 disabled then enabled
        put_rule(0, 8, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        filer_en = 1'b0;
        q_en = '1; q_en[0] = 1'b0;
        run_frame(lat);
        expect_result("R10", lat, 2, 0, 0, 1, 0);
        q_en = '1;
        run_frame(lat);
        expect_result("R10", lat, 2, 0, 0, 0, 0);
        filer_en = 1'b1;
        fail_rule(0);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: fill the table with always-fail rules
        for (int i = 0; i < N_RULES; i++) fail_rule(i);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_compare();
        test_mask();
        test_chain();
        test_reject_gpi();
        test_qdis();
        test_nomatch();
        test_partial();
        test_bypass();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule